// File: doc/BRIEF.md
# Cascaded 4-to-16 Active-Low Line Decoder

This block turns a 4-bit binary code into a one-cold pattern on sixteen active-low lines. It is built from two identical 3-to-8 stages. Each stage has three enable pins: one active-high and two active-low. A stage decodes only when the high pin is 1 and both low pins are 0. Otherwise it holds all eight of its lines high.

The top bit of the code acts as a chip select. Only one stage is enabled for any code, so at most one of the sixteen lines is low. A global active-high enable gates both stages. When it is 0, every line is high whatever the code. The block is purely combinational and has no registers. It suits address-style selection, where exactly one downstream target must be chosen or none at all.

Top module: `hex_line_decoder`

## Requirements
- R1: With `enable_in` = 1, line `lines_n[k]` is 0, where k is the unsigned value of `code_in`, and every other line is 1.
- R2: With `enable_in` = 0, all sixteen lines are 1 for every value of `code_in`.
- R3: At no time is more than one line of `lines_n` at 0.
- R4: Bit 3 of `code_in` selects the stage. When it is 0, only lines 7..0 may be low and lines 15..8 are all 1. When it is 1, only lines 15..8 may be low and lines 7..0 are all 1.
- R5: Within a stage, code bits 2, 1 and 0 carry weights 4, 2 and 1. For example, code 4'b0110 pulls line 6 low, and code 4'b1011 pulls line 11 low.
- R6: The outputs follow a change of `code_in` or `enable_in` with no clock edge in between, because the block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| code_in | input | 4 | Binary code to decode; bit 3 chooses the stage |
| enable_in | input | 1 | Global enable, active high |
| lines_n | output | 16 | Decoded lines, active low, one-cold when enabled |

## Verification
The bench builds the block with its default parameters: 3 code bits per stage and 1 stage-select bit. At that size the whole input space is only 32 patterns, so the bench drives every code with the enable both on and off. It compares the full 16-line vector against a behavioural model, which covers both stage halves and the stage boundary between codes 7 and 8. A change of the inputs in the middle of a cycle is also checked, to show that the outputs respond without waiting for a clock.

// File: rtl/hexdec_pkg.sv
// Package: shared types for the cascaded line decoder.
// Assumes: a stage enable is a triple made of one active-high pin and two
// active-low pins.
package hexdec_pkg;

    // Enable pins of one decode stage.
    typedef struct packed {
        logic act_hi;    // must be 1 for the stage to decode
        logic act_lo_a;  // must be 0 for the stage to decode
        logic act_lo_b;  // must be 0 for the stage to decode
    } stage_en_t;

endpackage

// File: rtl/oct_stage.sv
// Module: oct_stage
// One 2**CODE_W-line decode stage with a mixed-polarity three-pin enable.
// Assumes: a purely combinational use. A disabled stage holds every line high.
module oct_stage
    import hexdec_pkg::*;
#(
    parameter int unsigned CODE_W = 3
) (
    input  logic [CODE_W-1:0]      sel,
    input  stage_en_t              en,
    output logic [2**CODE_W-1:0]   out_n
);
    localparam int unsigned LINES = 2**CODE_W;

    logic live;

    // Combine the three enable pins into a single decode permission.
    always_comb begin
        live = en.act_hi & ~en.act_lo_a & ~en.act_lo_b;
    end

    // One comparator per output line; a line goes low only on its own code.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign out_n[g] = ~(live && (sel == CODE_W'(g)));
    end

endmodule

// File: rtl/bank_gate.sv
// Module: bank_gate
// Builds the enable triple for each stage from the bank bits and the global
// enable. Assumes: exactly one stage is addressed by any value of the bank bits.
module bank_gate
    import hexdec_pkg::*;
#(
    parameter int unsigned BANK_W = 1
) (
    input  logic [BANK_W-1:0]  bank,
    input  logic               glob_en,
    output stage_en_t          en_vec [2**BANK_W]
);
    localparam int unsigned BANKS = 2**BANK_W;

    // Per stage: the high pin carries the global enable, one low pin carries
    // the bank mismatch, and the other low pin is held inactive.
    for (genvar k = 0; k < BANKS; k++) begin : g_bank
        always_comb begin
            en_vec[k].act_hi   = glob_en;
            en_vec[k].act_lo_a = (bank != BANK_W'(k));
            en_vec[k].act_lo_b = 1'b0;
        end
    end

endmodule

// File: rtl/hex_line_decoder.sv
// Module: hex_line_decoder
// Cascaded active-low decoder: the upper code bits pick one stage, and the
// lower bits pick a line within that stage. Assumes: purely combinational,
// with no clock or reset.
module hex_line_decoder
    import hexdec_pkg::*;
#(
    parameter int unsigned CODE_W = 3,
    parameter int unsigned BANK_W = 1
) (
    input  logic [CODE_W+BANK_W-1:0]         code_in,
    input  logic                             enable_in,
    output logic [2**(CODE_W+BANK_W)-1:0]    lines_n
);
    localparam int unsigned STAGE_LINES = 2**CODE_W;
    localparam int unsigned BANKS       = 2**BANK_W;

    stage_en_t en_vec [BANKS];

    // Chip-select wiring for all stages.
    bank_gate #(.BANK_W(BANK_W)) u_bank_gate (
        .bank    (code_in[CODE_W+BANK_W-1:CODE_W]),
        .glob_en (enable_in),
        .en_vec  (en_vec)
    );

    // One identical stage per bank, each placed on its own slice of lines.
    for (genvar k = 0; k < BANKS; k++) begin : g_stage
        oct_stage #(.CODE_W(CODE_W)) u_stage (
            .sel   (code_in[CODE_W-1:0]),
            .en    (en_vec[k]),
            .out_n (lines_n[k*STAGE_LINES +: STAGE_LINES])
        );
    end

endmodule

// File: rtl/hex_line_decoder_chk.sv
// Module: hex_line_decoder_chk
// Port-level checker for hex_line_decoder, bound to every instance.
// Assumes: combinational behaviour, so the checks are immediate and re-evaluated
// whenever the inputs or outputs change.
module hex_line_decoder_chk #(
    parameter int unsigned CODE_W = 3,
    parameter int unsigned BANK_W = 1
) (
    input  logic [CODE_W+BANK_W-1:0]         code_in,
    input  logic                             enable_in,
    input  logic [2**(CODE_W+BANK_W)-1:0]    lines_n
);
    localparam int unsigned TOTAL  = 2**(CODE_W+BANK_W);
    localparam int unsigned SLICE  = 2**CODE_W;

    logic [TOTAL-1:0] bank_mask;

    // Mask of the lines that belong to the addressed stage.
    always_comb begin
        bank_mask = {{(TOTAL-SLICE){1'b0}}, {SLICE{1'b1}}}
                    << (SLICE * code_in[CODE_W+BANK_W-1:CODE_W]);
    end

    // Line-level properties checked on any change.
    always_comb begin
        if (enable_in) begin
            AST_HIT_LINE_LOW: assert (lines_n[code_in] == 1'b0);            // R1
            AST_OTHER_BANK_HIGH: assert (((~lines_n) & ~bank_mask) == '0);  // R4
        end else begin
            AST_IDLE_ALL_HIGH: assert (&lines_n);                           // R2
        end
        AST_ONE_COLD: assert ($countones(~lines_n) <= 1);                   // R3
    end

endmodule

bind hex_line_decoder hex_line_decoder_chk #(
    .CODE_W(CODE_W),
    .BANK_W(BANK_W)
) i_chk (
    .code_in   (code_in),
    .enable_in (enable_in),
    .lines_n   (lines_n)
);

// File: tb/test_hex_line_decoder.sv
// Bench for hex_line_decoder: a behavioural model, compared on every falling edge.
module test_hex_line_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  code_in = 4'd0;
    logic        enable_in = 1'b0;
    logic [15:0] lines_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // 50 MHz clock.
    always #10 clk = ~clk;

    hex_line_decoder i_hex_line_decoder (
        .code_in   (code_in),
        .enable_in (enable_in),
        .lines_n   (lines_n)
    );

    // Record one check and report a mismatch.
    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s code=%0d en=%0b actual=%h expected=%h", req, code_in, enable_in, act, exp);
        end
    endtask

    // Behavioural model of the sixteen lines.
    function automatic logic [15:0] model(input logic [3:0] c, input logic e);
        logic [15:0] v = 16'hFFFF;
        if (e) v[c] = 1'b0;
        return v;
    endfunction

    // Compare against the model on every falling edge, away from input changes.
    always @(negedge clk) begin
        if (!rst_n) begin
            check("R2 reset", lines_n, 16'hFFFF);
        end else if (!done) begin
            check(enable_in ? "R1" : "R2", lines_n, model(code_in, enable_in));
            check("R3", 16'($countones(~lines_n) <= 1), 16'd1);
            if (code_in[3]) check("R4", {8'h00, lines_n[7:0]}, 16'h00FF);
            else            check("R4", {lines_n[15:8], 8'h00}, 16'hFF00);
            if (enable_in && code_in == 4'b0110) check("R5", 16'(lines_n[6]), 16'd0);
            if (enable_in && code_in == 4'b1011) check("R5", 16'(lines_n[11]), 16'd0);
        end
    end

    // Stimulus: reset, then every code with the enable off and then on.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        for (int e = 0; e < 2; e++) begin
            for (int c = 0; c < 16; c++) begin
                @(posedge clk); #2;
                code_in = 4'(c);
                enable_in = e[0];
            end
        end
        // R6: change the inputs mid-cycle and look before any clock edge.
        @(negedge clk); #3;
        code_in = 4'd9; enable_in = 1'b1; #1;
        check("R6", lines_n, 16'hFDFF);
        enable_in = 1'b0; #1;
        check("R6", lines_n, 16'hFFFF);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule